// File: doc/BRIEF.md
# Oversampling Serial Receiver with Holding Register

This block takes an asynchronous serial line and turns its frames into parallel characters. A timing tick, pulsed sixteen times per bit period by a rate generator outside the block, drives an internal tick counter. The idle line is high. A falling edge on the line, once the line has been seen high, starts a frame. Three samples near the centre of each bit are combined by majority vote into one bit level. Data arrives least significant bit first into a serial shifter. An optional ninth data bit can follow, and a stop bit ends the frame.

When a frame completes, the shifter contents move in one step into a holding register, and a full flag tells the host a character is waiting. A new frame can shift in while the previous character waits. A read strobe from the host empties the holding register and clears all flags. If a frame completes while the previous character has not been read, the old character is kept, the new one is discarded, and an overrun flag is raised. A start edge that proves false on its centre vote is dropped, and the counter re-aligns on the next real edge.

Top module: `uart_os_rx`

## Requirements
- R1: While `rx_en` is low, the frame engine stays idle with its tick counter cleared and start search disarmed. A complete frame sent while `rx_en` is low leaves `rx_full` at 0.
- R2: A frame is a start bit (0), then 8 data bits least significant bit first, then a stop bit. The data bits appear on `rx_data` with bit 0 taken from the first data bit sent.
- R3: With `nine_bit_mode` at 1, a ninth data bit follows the eighth and appears on `rx_bit8` on the same clock edge that the byte reaches `rx_data`. In 8-bit mode, `rx_bit8` is loaded with 0.
- R4: A stop-bit vote of 0 sets `frame_err`. The character is still transferred when the holding register is empty.
- R5: Reset clears `rx_full`, `frame_err`, `overrun`, `rx_data` and `rx_bit8`. When a frame completes with `rx_full` low, the character is loaded and `rx_full` goes to 1.
- R6: When a frame completes with `rx_full` already 1, `rx_data` and `rx_bit8` keep their old values, the new character is lost, and `overrun` goes to 1.
- R7: Each bit lasts 16 ticks, counted from the tick that detects the start edge, which is tick 1. The bit level is the majority of the line at ticks 8, 9 and 10, so a one-tick disturbance at tick 9 does not change the received bit.
- R8: If the start-bit vote is 1, the frame is abandoned with no transfer and no flag, and the next real start edge restarts the tick count.
- R9: A one-cycle `cpu_read` pulse clears `rx_full`, `frame_err` and `overrun`. When a frame completes in the same cycle, the flags that frame sets win, and the overrun decision uses `rx_full` as it was before the read.
- R10: Start search arms only after the line is sampled high on a tick. A line held low from enable onward starts no frame.
- R11: The receiver returns to start search directly after the stop-bit vote, so a frame whose start edge follows the previous stop bit with no idle gap is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_line | input | 1 | Asynchronous serial input, high when idle |
| rx_en | input | 1 | Receiver enable; low holds the frame engine in its initial state |
| nine_bit_mode | input | 1 | 1 selects frames with a ninth data bit |
| os_tick | input | 1 | Oversampling enable, one clock wide, 16 per bit period |
| cpu_read | input | 1 | Host read strobe; clears the full, framing and overrun flags |
| rx_data | output | 8 | Holding register: last accepted character |
| rx_bit8 | output | 1 | Ninth data bit of the last accepted character |
| rx_full | output | 1 | A character waits in the holding register |
| frame_err | output | 1 | A stop bit was sampled low |
| overrun | output | 1 | A character was lost because the holding register was full |

## Verification
Checked on every cycle: the idle hold under a low enable, the tick counter range, the loading of the holding register whenever a frame completes into an empty register, and the holding register staying unchanged while it is full. Also checked every cycle: the overrun flag on a blocked transfer, the framing flag on a low stop vote, and the clearing done by a read. Only the bench scenarios can show the end-to-end results. These are correct bit order and ninth-bit placement for real line waveforms, immunity to a one-tick glitch, abandonment of a false start followed by correct reception, the need to see the line high before arming, and acceptance of back-to-back frames.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_NINTH = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d};
  end

  // idle line level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/uart_os_rx_vote.sv
module uart_os_rx_vote #(
  parameter  int TPB   = 16,
  parameter  int MID   = 9,
  localparam int CNT_W = $clog2(TPB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             line,
  output logic             vote,
  output logic             vote_valid
);

  // cnt holds ticks already seen in the bit, so tick k is seen with cnt == k-1
  localparam logic [CNT_W-1:0] TAP_A = CNT_W'(MID - 2);
  localparam logic [CNT_W-1:0] TAP_B = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] TAP_C = CNT_W'(MID);

  logic samp_a_q, samp_a_d;
  logic samp_b_q, samp_b_d;

  always_comb begin
    samp_a_d = samp_a_q;
    samp_b_d = samp_b_q;
    if (tick && active && (cnt == TAP_A)) samp_a_d = line;
    if (tick && active && (cnt == TAP_B)) samp_b_d = line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_a_q <= 1'b1;
      samp_b_q <= 1'b1;
    end else begin
      samp_a_q <= samp_a_d;
      samp_b_q <= samp_b_d;
    end
  end

  assign vote       = (samp_a_q & samp_b_q) | (samp_a_q & line) | (samp_b_q & line);
  assign vote_valid = tick && active && (cnt == TAP_C);

endmodule

// File: rtl/uart_os_rx_ctrl.sv
module uart_os_rx_ctrl
  import uart_os_rx_pkg::*;
#(
  parameter  int TPB       = 16,
  parameter  int DATA_BITS = 8,
  localparam int CNT_W     = $clog2(TPB + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 nine_mode,
  input  logic                 tick,
  input  logic                 line,
  input  logic                 vote,
  input  logic                 vote_valid,
  output rx_state_e            state,
  output logic [CNT_W-1:0]     cnt,
  output logic                 active,
  output logic                 load,
  output logic                 stop_ok,
  output logic [DATA_BITS-1:0] char_byte,
  output logic                 char_bit8
);

  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(TPB);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  rx_state_e            state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [DATA_BITS-1:0] shf_q, shf_d;
  logic                 b8_q, b8_d;
  logic                 armed_q, armed_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shf_d   = shf_q;
    b8_d    = b8_q;
    armed_d = armed_q;
    load    = 1'b0;
    if (!en) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
      idx_d   = '0;
      armed_d = 1'b0;
    end else if (tick) begin
      if (state_q == RX_IDLE) begin
        if (line) begin
          armed_d = 1'b1;
        end else if (armed_q) begin
          state_d = RX_START;
          cnt_d   = CNT_ONE;
          armed_d = 1'b0;
        end
      end else begin
        cnt_d = (cnt_q == CNT_TOP) ? CNT_ONE : cnt_q + 1'b1;
        if (vote_valid) begin
          case (state_q)
            RX_START: begin
              if (vote) begin
                // false start: drop it and re-align on the next edge
                state_d = RX_IDLE;
                cnt_d   = '0;
                armed_d = 1'b1;
              end else begin
                state_d = RX_DATA;
                idx_d   = '0;
                b8_d    = 1'b0;
              end
            end
            RX_DATA: begin
              shf_d = {vote, shf_q[DATA_BITS-1:1]};
              if (idx_q == LAST_IDX) begin
                idx_d   = '0;
                state_d = nine_mode ? RX_NINTH : RX_STOP;
              end else begin
                idx_d = idx_q + 1'b1;
              end
            end
            RX_NINTH: begin
              b8_d    = vote;
              state_d = RX_STOP;
            end
            RX_STOP: begin
              load    = 1'b1;
              state_d = RX_IDLE;
              cnt_d   = '0;
              armed_d = vote;
            end
            default: state_d = RX_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
      b8_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
      b8_q    <= b8_d;
      armed_q <= armed_d;
    end
  end

  assign state     = state_q;
  assign cnt       = cnt_q;
  assign active    = (state_q != RX_IDLE);
  assign stop_ok   = vote;
  assign char_byte = shf_q;
  assign char_bit8 = b8_q;

endmodule

// File: rtl/uart_os_rx_buf.sv
module uart_os_rx_buf #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 stop_ok,
  input  logic [DATA_BITS-1:0] char_byte,
  input  logic                 char_bit8,
  input  logic                 cpu_read,
  output logic [DATA_BITS-1:0] data,
  output logic                 bit8,
  output logic                 full,
  output logic                 fe,
  output logic                 ov
);

  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 bit8_q, bit8_d;
  logic                 full_q, full_d;
  logic                 fe_q, fe_d;
  logic                 ov_q, ov_d;

  always_comb begin
    data_d = data_q;
    bit8_d = bit8_q;
    full_d = full_q;
    fe_d   = fe_q;
    ov_d   = ov_q;
    if (cpu_read) begin
      full_d = 1'b0;
      fe_d   = 1'b0;
      ov_d   = 1'b0;
    end
    // a completing frame wins over a read in the same cycle
    if (load) begin
      if (!stop_ok) fe_d = 1'b1;
      if (!full_q) begin
        data_d = char_byte;
        bit8_d = char_bit8;
        full_d = 1'b1;
      end else begin
        ov_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      bit8_q <= 1'b0;
      full_q <= 1'b0;
      fe_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      bit8_q <= bit8_d;
      full_q <= full_d;
      fe_q   <= fe_d;
      ov_q   <= ov_d;
    end
  end

  assign data = data_q;
  assign bit8 = bit8_q;
  assign full = full_q;
  assign fe   = fe_q;
  assign ov   = ov_q;

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int SAMPLE_MID    = 9,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  input  logic                 rx_en,
  input  logic                 nine_bit_mode,
  input  logic                 os_tick,
  input  logic                 cpu_read,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_bit8,
  output logic                 rx_full,
  output logic                 frame_err,
  output logic                 overrun
);

  localparam int CNT_W = $clog2(TICKS_PER_BIT + 1);

  logic [1:0]           rst_pipe_q;
  logic                 rst_n_int;
  logic                 line_s;
  rx_state_e            state_w;
  logic [CNT_W-1:0]     cnt_w;
  logic                 active_w;
  logic                 vote_w;
  logic                 vote_valid_w;
  logic                 load_w;
  logic                 stop_ok_w;
  logic [DATA_BITS-1:0] byte_w;
  logic                 bit8_w;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (rx_line),
    .q     (line_s)
  );

  uart_os_rx_vote #(.TPB(TICKS_PER_BIT), .MID(SAMPLE_MID)) u_vote (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .active     (active_w),
    .tick       (os_tick),
    .cnt        (cnt_w),
    .line       (line_s),
    .vote       (vote_w),
    .vote_valid (vote_valid_w)
  );

  uart_os_rx_ctrl #(.TPB(TICKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .en         (rx_en),
    .nine_mode  (nine_bit_mode),
    .tick       (os_tick),
    .line       (line_s),
    .vote       (vote_w),
    .vote_valid (vote_valid_w),
    .state      (state_w),
    .cnt        (cnt_w),
    .active     (active_w),
    .load       (load_w),
    .stop_ok    (stop_ok_w),
    .char_byte  (byte_w),
    .char_bit8  (bit8_w)
  );

  uart_os_rx_buf #(.DATA_BITS(DATA_BITS)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load      (load_w),
    .stop_ok   (stop_ok_w),
    .char_byte (byte_w),
    .char_bit8 (bit8_w),
    .cpu_read  (cpu_read),
    .data      (rx_data),
    .bit8      (rx_bit8),
    .full      (rx_full),
    .fe        (frame_err),
    .ov        (overrun)
  );

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk
  import uart_os_rx_pkg::*;
#(
  parameter  int DATA_BITS = 8,
  parameter  int TPB       = 16,
  localparam int CNT_W     = $clog2(TPB + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_en,
  input logic                 cpu_read,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_full,
  input logic                 frame_err,
  input logic                 overrun,
  input rx_state_e            state,
  input logic [CNT_W-1:0]     cnt,
  input logic                 load,
  input logic                 stop_ok,
  input logic [DATA_BITS-1:0] char_byte
);

  assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state == RX_IDLE && cnt == '0));

  assert_bad_stop_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !stop_ok) |=> frame_err);

  assert_load_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !rx_full) |=> (rx_full && rx_data == $past(char_byte)));

  assert_full_holds_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> $stable(rx_data));

  assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && rx_full) |=> overrun);

  assert_tick_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(TPB));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_read && !load) |=> (!rx_full && !frame_err && !overrun));

endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_BITS(DATA_BITS), .TPB(TICKS_PER_BIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .cpu_read  (cpu_read),
  .rx_data   (rx_data),
  .rx_full   (rx_full),
  .frame_err (frame_err),
  .overrun   (overrun),
  .state     (state_w),
  .cnt       (cnt_w),
  .load      (load_w),
  .stop_ok   (stop_ok_w),
  .char_byte (byte_w)
);

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;

  logic       clk;
  logic       rst_n;
  logic       rx_line;
  logic       rx_en;
  logic       nine_bit_mode;
  logic       os_tick;
  logic       cpu_read;
  logic [7:0] rx_data;
  logic       rx_bit8;
  logic       rx_full;
  logic       frame_err;
  logic       overrun;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  uart_os_rx u_uart_os_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_line       (rx_line),
    .rx_en         (rx_en),
    .nine_bit_mode (nine_bit_mode),
    .os_tick       (os_tick),
    .cpu_read      (cpu_read),
    .rx_data       (rx_data),
    .rx_bit8       (rx_bit8),
    .rx_full       (rx_full),
    .frame_err     (frame_err),
    .overrun       (overrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // one tick every four clocks, changed on the falling edge
  initial begin
    os_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  // vector: {nine, stop level, nine-bit payload}
  localparam logic [10:0] VEC [0:5] = '{
    {1'b0, 1'b1, 9'h0A5},
    {1'b1, 1'b1, 9'h1C3},
    {1'b0, 1'b0, 9'h07E},
    {1'b1, 1'b1, 9'h055},
    {1'b1, 1'b0, 9'h180},
    {1'b0, 1'b1, 9'h1FF}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!os_tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input bit glitch);
    rx_line = v;
    if (glitch) begin
      wait_ticks(8);
      rx_line = ~v;
      wait_ticks(1);
      rx_line = v;
      wait_ticks(7);
    end else begin
      wait_ticks(16);
    end
  endtask

  task automatic send_frame(input logic nine, input logic [8:0] d, input logic stop, input int glitch_bit);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i], i == glitch_bit);
    if (nine) send_bit(d[8], 1'b0);
    send_bit(stop, 1'b0);
    rx_line = 1'b1;
  endtask

  task automatic host_read();
    @(negedge clk);
    cpu_read = 1'b1;
    @(negedge clk);
    cpu_read = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n         = 1'b0;
    rx_line       = 1'b1;
    rx_en         = 1'b1;
    nine_bit_mode = 1'b0;
    cpu_read      = 1'b0;
    repeat (5) @(negedge clk);
    // R5: reset state
    chk("R5 reset flags", {13'd0, rx_full, frame_err, overrun}, 16'h0);
    chk("R5 reset data", {7'd0, rx_bit8, rx_data}, 16'h0);
    rst_n = 1'b1;
    wait_ticks(6);

    // table of frames
    for (int v = 0; v < 6; v++) begin
      logic       nine;
      logic       stop;
      logic [8:0] d;
      {nine, stop, d} = VEC[v];
      host_read();
      nine_bit_mode = nine;
      wait_ticks(3);
      send_frame(nine, d, stop, -1);
      wait_ticks(2);
      chk("R2 data byte", {8'd0, rx_data}, {8'd0, d[7:0]});
      chk("R3 ninth bit", {15'd0, rx_bit8}, {15'd0, nine & d[8]});
      chk("R4 framing flag", {15'd0, frame_err}, {15'd0, ~stop});
      chk("R5 full set", {15'd0, rx_full}, 16'h1);
    end

    // R9: read clears everything (last vector left full set)
    host_read();
    chk("R9 read clears", {13'd0, rx_full, frame_err, overrun}, 16'h0);
    nine_bit_mode = 1'b0;

    // R7: one-tick glitch at tick 9 of data bits 3 and 6
    wait_ticks(3);
    send_frame(1'b0, 9'h05A, 1'b1, 3);
    wait_ticks(2);
    chk("R7 glitch bit3", {8'd0, rx_data}, 16'h005A);
    host_read();
    send_frame(1'b0, 9'h0F0, 1'b1, 6);
    wait_ticks(2);
    chk("R7 glitch bit6", {8'd0, rx_data}, 16'h00F0);
    host_read();

    // R8: short low pulse, then a real frame
    wait_ticks(3);
    rx_line = 1'b0;
    wait_ticks(4);
    rx_line = 1'b1;
    wait_ticks(20);
    chk("R8 false start no load", {13'd0, rx_full, frame_err, overrun}, 16'h0);
    send_frame(1'b0, 9'h0C9, 1'b1, -1);
    wait_ticks(2);
    chk("R8 resync frame", {7'd0, rx_full, rx_data}, 16'h01C9);
    host_read();

    // R1: frame while disabled
    rx_en = 1'b0;
    wait_ticks(2);
    send_frame(1'b0, 9'h033, 1'b1, -1);
    wait_ticks(2);
    chk("R1 disabled no load", {13'd0, rx_full, frame_err, overrun}, 16'h0);

    // R10: enable with line low, held low
    rx_line = 1'b0;
    wait_ticks(2);
    rx_en = 1'b1;
    wait_ticks(200);
    chk("R10 low line no start", {13'd0, rx_full, frame_err, overrun}, 16'h0);
    rx_line = 1'b1;
    wait_ticks(20);
    send_frame(1'b0, 9'h03C, 1'b1, -1);
    wait_ticks(2);
    chk("R10 armed frame", {7'd0, rx_full, rx_data}, 16'h013C);
    host_read();

    // R11: back-to-back frames, host reads between them
    wait_ticks(3);
    fork
      begin
        send_frame(1'b0, 9'h011, 1'b1, -1);
        send_frame(1'b0, 9'h0EE, 1'b1, -1);
      end
      begin
        wait (rx_full);
        host_read();
      end
    join
    wait_ticks(2);
    chk("R11 second frame", {7'd0, rx_full, rx_data}, 16'h01EE);
    chk("R11 no overrun", {15'd0, overrun}, 16'h0);
    host_read();

    // R6: back-to-back frames without read
    nine_bit_mode = 1'b1;
    wait_ticks(3);
    send_frame(1'b1, 9'h1A1, 1'b1, -1);
    send_frame(1'b1, 9'h05E, 1'b1, -1);
    wait_ticks(2);
    chk("R6 data kept", {7'd0, rx_bit8, rx_data}, 16'h01A1);
    chk("R6 overrun set", {14'd0, rx_full, overrun}, 16'h3);
    host_read();
    chk("R9 overrun cleared", {13'd0, rx_full, frame_err, overrun}, 16'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule